// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Registered Flag Byte

This block is the arithmetic core of a small 8-bit processor datapath. Each cycle it takes an operation code, the accumulator, one 8-bit operand and, for the two wide operations, a pair of 16-bit values. It returns the new 8-bit result and the new 16-bit result combinationally. The flag byte is produced in the same cycle and captured in an internal register when `op_en` is high. The stored carry (bit 0 of that register) is the carry or borrow input for add-with-carry, subtract-with-borrow and the through-carry rotates.

Instruction decode, the register file and memory sit outside the block. The caller routes the outputs back into its own registers: `result` for the 8-bit operations and `wide_res` for the 16-bit ones. Flag bits keep fixed positions: sign 7, zero 6, spare 5, half-carry 4, spare 3, overflow/parity 2, subtract 1, carry 0. The spare bits are written as 0 by the arithmetic and logical groups and are kept by the rotates and the wide add.

Top module: `alu8_core`

## Requirements
- R1: `op_sel` codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment, 9 decrement, 10 rotate-left circular, 11 rotate-right circular, 12 rotate-left through carry, 13 rotate-right through carry, 14 wide add, 15 wide subtract. For codes 14 and 15, `result` equals `acc_in`. For codes 0 to 13, `wide_res` equals `wide_a`.
- R2: The flag register resets asynchronously to 0x00 while `rst_n` is low and stays 0x00 until the first enabled operation after release. It loads the new flag byte only on a rising clock edge with `op_en` high; otherwise it holds.
- R3: For codes 0 to 3 the result is `acc_in` plus or minus `opnd_in`, with the stored carry added (code 1) or subtracted (code 3). The flag byte is set as follows:
  - bit 7 is result bit 7;
  - bit 6 is set when the result is zero;
  - bit 4 is bit 4 of `acc_in ^ opnd_in ^ result`;
  - bit 2 is signed overflow;
  - bit 1 is set for subtraction;
  - bit 0 is bit 8 of the 9-bit sum or difference;
  - bits 5 and 3 are 0.
- R4: Compare (code 4) sets flags exactly as subtract does, and `result` equals `acc_in`.
- R5: AND, OR and XOR set the flag byte as follows:
  - bit 7 is the sign of the result;
  - bit 6 is the zero test;
  - bit 2 is 1 when the result has an even number of ones;
  - bit 4 is 1 for AND and 0 for OR and XOR;
  - all other bits are 0.
- R6: Increment and decrement act on `opnd_in` and keep the stored carry. The other flag bits are set as follows:
  - Increment: bit 2 is set when the result is 0x80, and bit 4 is set when the result's low nibble is 0.
  - Decrement: bit 2 is set when the operand is 0x80, bit 4 is set when the operand's low nibble is 0, and bit 1 is set.
  - Both: bits 7 and 6 come from the result, and bits 5 and 3 are 0.
- R7: The rotates act on `acc_in`. Carry is loaded from the bit shifted out, bits 4 and 1 are cleared, and every other flag bit is kept. The through-carry rotates shift the stored carry in.
- R8: Wide add gives `wide_a + wide_b` modulo 2^16. It writes only two flags: bit 4 (bit 12 of `wide_a ^ wide_b ^ sum`) and bit 0 (bit 16 of the sum). All other flag bits are kept.
- R9: Wide subtract computes `wide_a - wide_b` in two steps: first the low bytes, then the high bytes with the low borrow subtracted. Sign, half-carry, overflow and carry come from the high step, and bit 1 is set. Zero is set only when both result bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_en | input | 1 | Load the new flag byte at the next rising edge |
| op_sel | input | 4 | Operation code (R1) |
| acc_in | input | 8 | Accumulator |
| opnd_in | input | 8 | 8-bit operand |
| wide_a | input | 16 | Wide first operand (destination pair) |
| wide_b | input | 16 | Wide second operand |
| result | output | 8 | 8-bit result |
| wide_res | output | 16 | 16-bit result |
| flags_q | output | 8 | Registered flag byte |

## Verification
The write-back of a carry and its consumption by the next operation meet at the same clock edge. One cycle's borrow or shifted-out bit lands in the flag register exactly as the following add-with-carry, subtract-with-borrow, through-carry rotate or increment/decrement reads or preserves it. The bench provokes this by issuing every swept operation on the cycle straight after an operation that forces the carry to 0 or 1, with no idle gap. Each result and flag byte is judged against a model whose flag state is advanced only by the bench's own expected values.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_RLC  = 4'd10,
    OP_RRC  = 4'd11,
    OP_RAL  = 4'd12,
    OP_RAR  = 4'd13,
    OP_WADD = 4'd14,
    OP_WSUB = 4'd15
  } alu_op_e;

  localparam int FW  = 8;
  localparam int NIB = 4;

  localparam int F_S = 7;
  localparam int F_Z = 6;
  localparam int F_H = 4;
  localparam int F_V = 2;
  localparam int F_N = 1;
  localparam int F_C = 0;

  localparam logic [FW-1:0] ROT_CLR = FW'((1 << F_H) | (1 << F_N) | (1 << F_C));

endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/1ps
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            cin,
  output logic [DW-1:0]   res,
  output logic [FW-1:0]   flg
);

  localparam int MSB = DW - 1;
  localparam logic [DW-1:0] MINNEG = {1'b1, {MSB{1'b0}}};
  localparam logic [DW-1:0] ONE    = {{MSB{1'b0}}, 1'b1};

  logic          is_sub;
  logic          cuse;
  logic [DW:0]   sum_w;
  logic [DW:0]   dif_w;
  logic [DW:0]   ext_w;
  logic [DW-1:0] r8;
  logic [DW-1:0] step_w;
  logic          hc;
  logic          ovf;

  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    cuse   = cin && ((op == OP_ADC) || (op == OP_SBB));
    sum_w  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cuse};
    dif_w  = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cuse};
    ext_w  = is_sub ? dif_w : sum_w;
    r8     = ext_w[MSB:0];
    hc     = a[NIB] ^ b[NIB] ^ r8[NIB];
    ovf    = is_sub ? ((a[MSB] ^ b[MSB]) & (a[MSB] ^ r8[MSB]))
                    : (~(a[MSB] ^ b[MSB]) & (a[MSB] ^ r8[MSB]));
    step_w = (op == OP_DEC) ? (b - ONE) : (b + ONE);

    flg = '0;
    res = r8;
    case (op)
      OP_INC, OP_DEC: begin
        res      = step_w;
        flg[F_S] = step_w[MSB];
        flg[F_Z] = ~|step_w;
        flg[F_C] = cin;
        if (op == OP_INC) begin
          flg[F_H] = ~|step_w[NIB-1:0];
          flg[F_V] = (step_w == MINNEG);
        end else begin
          flg[F_H] = ~|b[NIB-1:0];
          flg[F_V] = (b == MINNEG);
          flg[F_N] = 1'b1;
        end
      end
      default: begin
        if (op == OP_CMP) res = a;
        flg[F_S] = r8[MSB];
        flg[F_Z] = ~|r8;
        flg[F_H] = hc;
        flg[F_V] = ovf;
        flg[F_N] = is_sub;
        flg[F_C] = ext_w[DW];
      end
    endcase
  end

endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [FW-1:0]   fin,
  output logic [DW-1:0]   res,
  output logic [FW-1:0]   flg
);

  localparam int MSB = DW - 1;

  logic          is_rot;
  logic          cout;
  logic [DW-1:0] lr;

  always_comb begin
    is_rot = op inside {OP_RLC, OP_RRC, OP_RAL, OP_RAR};
    cout   = 1'b0;
    case (op)
      OP_OR:   lr = a | b;
      OP_XOR:  lr = a ^ b;
      OP_RLC:  begin lr = {a[MSB-1:0], a[MSB]};    cout = a[MSB]; end
      OP_RRC:  begin lr = {a[0], a[MSB:1]};        cout = a[0];   end
      OP_RAL:  begin lr = {a[MSB-1:0], fin[F_C]};  cout = a[MSB]; end
      OP_RAR:  begin lr = {fin[F_C], a[MSB:1]};    cout = a[0];   end
      default: lr = a & b;
    endcase

    res = lr;
    if (is_rot) begin
      flg      = fin & ~ROT_CLR;
      flg[F_C] = cout;
    end else begin
      flg      = '0;
      flg[F_S] = lr[MSB];
      flg[F_Z] = ~|lr;
      flg[F_V] = ~^lr;
      flg[F_H] = (op == OP_AND);
    end
  end

endmodule

// File: rtl/alu8_wide.sv
`timescale 1ns/1ps
module alu8_wide
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e           op,
  input  logic [2*DW-1:0]   wa,
  input  logic [2*DW-1:0]   wb,
  input  logic [FW-1:0]     fin,
  output logic [2*DW-1:0]   wres,
  output logic [FW-1:0]     flg
);

  localparam int MSB = DW - 1;
  localparam int WW  = 2 * DW;

  logic [WW:0]   wsum;
  logic [DW:0]   lo_d;
  logic [DW:0]   hi_d;
  logic [DW-1:0] ah;
  logic [DW-1:0] bh;

  always_comb begin
    wsum = {1'b0, wa} + {1'b0, wb};
    ah   = wa[WW-1:DW];
    bh   = wb[WW-1:DW];
    lo_d = {1'b0, wa[MSB:0]} - {1'b0, wb[MSB:0]};
    hi_d = {1'b0, ah} - {1'b0, bh} - {{DW{1'b0}}, lo_d[DW]};

    if (op == OP_WSUB) begin
      wres     = {hi_d[MSB:0], lo_d[MSB:0]};
      flg      = '0;
      flg[F_S] = hi_d[MSB];
      flg[F_Z] = (~|hi_d[MSB:0]) & (~|lo_d[MSB:0]);
      flg[F_H] = ah[NIB] ^ bh[NIB] ^ hi_d[NIB];
      flg[F_V] = (ah[MSB] ^ bh[MSB]) & (ah[MSB] ^ hi_d[MSB]);
      flg[F_N] = 1'b1;
      flg[F_C] = hi_d[DW];
    end else begin
      wres     = wsum[WW-1:0];
      flg      = fin;
      flg[F_H] = wa[DW+NIB] ^ wb[DW+NIB] ^ wsum[DW+NIB];
      flg[F_C] = wsum[WW];
    end
  end

endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic [3:0]        op_sel,
  input  logic [DW-1:0]     acc_in,
  input  logic [DW-1:0]     opnd_in,
  input  logic [2*DW-1:0]   wide_a,
  input  logic [2*DW-1:0]   wide_b,
  output logic [DW-1:0]     result,
  output logic [2*DW-1:0]   wide_res,
  output logic [FW-1:0]     flags_q
);

  alu_op_e         op;
  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic [DW-1:0]   ar_res;
  logic [FW-1:0]   ar_flg;
  logic [DW-1:0]   lg_res;
  logic [FW-1:0]   lg_flg;
  logic [2*DW-1:0] wd_res;
  logic [FW-1:0]   wd_flg;
  logic [FW-1:0]   flag_new;
  logic [FW-1:0]   flag_d;

  assign op = alu_op_e'(op_sel);

  // reset: asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  alu8_arith #(.DW(DW)) u_arith (
    .op (op), .a (acc_in), .b (opnd_in), .cin (flags_q[F_C]),
    .res (ar_res), .flg (ar_flg)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op (op), .a (acc_in), .b (opnd_in), .fin (flags_q),
    .res (lg_res), .flg (lg_flg)
  );

  alu8_wide #(.DW(DW)) u_wide (
    .op (op), .wa (wide_a), .wb (wide_b), .fin (flags_q),
    .wres (wd_res), .flg (wd_flg)
  );

  always_comb begin
    result   = ar_res;
    wide_res = wide_a;
    flag_new = ar_flg;
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        result   = lg_res;
        flag_new = lg_flg;
      end
      OP_WADD, OP_WSUB: begin
        result   = acc_in;
        wide_res = wd_res;
        flag_new = wd_flg;
      end
      default: ;
    endcase
    flag_d = op_en ? flag_new : flags_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) flags_q <= '0;
    else            flags_q <= flag_d;
  end

endmodule

// File: rtl/alu8_core_chk.sv
`timescale 1ns/1ps
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_en,
  input logic [3:0]      op_sel,
  input logic [DW-1:0]   acc_in,
  input logic [DW-1:0]   result,
  input logic [DW-1:0]   wide_lo,
  input logic [FW-1:0]   flags_q
);

  logic is_rot;
  logic is_incdec;
  assign is_rot    = (op_sel >= 4'(OP_RLC)) && (op_sel <= 4'(OP_RAR));
  assign is_incdec = (op_sel == 4'(OP_INC)) || (op_sel == 4'(OP_DEC));

  // R1: wide operations leave the 8-bit result at the accumulator
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'(OP_WADD) || op_sel == 4'(OP_WSUB)) |-> result == acc_in);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(flags_q));

  p_cmp_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 4'(OP_CMP) |-> result == acc_in);

  p_and_hc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel == 4'(OP_AND)) |=> (flags_q[F_H] && !flags_q[F_C] && !flags_q[F_N]));

  p_incdec_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && is_incdec) |=> flags_q[F_C] == $past(flags_q[F_C]));

  p_rot_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && is_rot) |=> (flags_q[7:5] == $past(flags_q[7:5]) &&
                           flags_q[3:2] == $past(flags_q[3:2]) &&
                           !flags_q[F_H] && !flags_q[F_N]));

  p_wadd_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel == 4'(OP_WADD)) |=>
      ({flags_q[7:5], flags_q[3:1]} == {$past(flags_q[7:5]), $past(flags_q[3:1])}));

  p_wsub_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel == 4'(OP_WSUB) && wide_lo != '0) |=> !flags_q[F_Z]);

endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .op_en   (op_en),
  .op_sel  (op_sel),
  .acc_in  (acc_in),
  .result  (result),
  .wide_lo (wide_res[DW-1:0]),
  .flags_q (flags_q)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_en;
  logic [3:0]  op_sel;
  logic [7:0]  acc_in;
  logic [7:0]  opnd_in;
  logic [15:0] wide_a;
  logic [15:0] wide_b;
  logic [7:0]  result;
  logic [15:0] wide_res;
  logic [7:0]  flags_q;

  int n_run  = 0;
  int n_fail = 0;
  int mflags = 0;

  always #2.5 clk = ~clk;

  alu8_core u_dut (
    .clk (clk), .rst_n (rst_n), .op_en (op_en), .op_sel (op_sel),
    .acc_in (acc_in), .opnd_in (opnd_in), .wide_a (wide_a), .wide_b (wide_b),
    .result (result), .wide_res (wide_res), .flags_q (flags_q)
  );

  // {op, acc, operand, expected result, expected flags}, chained from flags 0x00
  localparam logic [35:0] TBL [16] = '{
    {4'd0,  8'hFF, 8'h01, 8'h00, 8'h51},
    {4'd1,  8'h10, 8'h20, 8'h31, 8'h00},
    {4'd2,  8'h00, 8'h01, 8'hFF, 8'h93},
    {4'd3,  8'h80, 8'h00, 8'h7F, 8'h16},
    {4'd4,  8'h42, 8'h42, 8'h42, 8'h42},
    {4'd5,  8'hF0, 8'h3C, 8'h30, 8'h14},
    {4'd7,  8'h55, 8'h55, 8'h00, 8'h44},
    {4'd6,  8'h80, 8'h01, 8'h81, 8'h84},
    {4'd8,  8'h00, 8'h7F, 8'h80, 8'h94},
    {4'd10, 8'h81, 8'h00, 8'h03, 8'h85},
    {4'd9,  8'h00, 8'h80, 8'h7F, 8'h17},
    {4'd13, 8'h01, 8'h00, 8'h80, 8'h05},
    {4'd12, 8'h00, 8'h00, 8'h01, 8'h04},
    {4'd11, 8'h01, 8'h00, 8'h80, 8'h05},
    {4'd8,  8'h00, 8'hFF, 8'h00, 8'h51},
    {4'd9,  8'h00, 8'h00, 8'hFF, 8'h93}
  };

  function automatic string req_tag(input int op);
    case (op)
      0, 1, 2, 3:     return "R3";
      4:              return "R4";
      5, 6, 7:        return "R5";
      8, 9:           return "R6";
      10, 11, 12, 13: return "R7";
      14:             return "R8";
      default:        return "R9";
    endcase
  endfunction

  function automatic int sz(input int r);
    return (r & 128) | ((r == 0) ? 64 : 0);
  endfunction

  function automatic void model(input int op, input int a, input int b,
                                input int wa, input int wb, input int fl,
                                output int r, output int wr, output int nf);
    int q, c, lo, hi, ah, bh, bl;
    logic [7:0] rv;
    c  = fl & 1;
    r  = a;
    wr = wa;
    nf = fl;
    case (op)
      0, 1: begin
        q  = a + b + ((op == 1) ? c : 0);
        r  = q & 255;
        nf = sz(r) | ((a ^ b ^ q) & 16) | ((((a ^ b ^ 128) & (b ^ q) & 128) != 0) ? 4 : 0)
             | ((q >> 8) & 1);
      end
      2, 3, 4: begin
        q  = a - b - ((op == 3) ? c : 0);
        r  = (op == 4) ? a : (q & 255);
        nf = sz(q & 255) | ((a ^ b ^ q) & 16) | ((((a ^ b) & (a ^ q) & 128) != 0) ? 4 : 0)
             | 2 | ((q >> 8) & 1);
      end
      5, 6, 7: begin
        r  = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (a ^ b);
        rv = r[7:0];
        nf = sz(r) | ((^rv) ? 0 : 4) | ((op == 5) ? 16 : 0);
      end
      8: begin
        r  = (b + 1) & 255;
        nf = c | sz(r) | ((r == 128) ? 4 : 0) | (((r & 15) == 0) ? 16 : 0);
      end
      9: begin
        r  = (b - 1) & 255;
        nf = c | 2 | sz(r) | ((b == 128) ? 4 : 0) | (((b & 15) == 0) ? 16 : 0);
      end
      10: begin r = ((a << 1) | (a >> 7)) & 255; nf = (fl & ~19) | (a >> 7); end
      11: begin r = ((a >> 1) | (a << 7)) & 255; nf = (fl & ~19) | (a & 1);  end
      12: begin r = ((a << 1) | c) & 255;        nf = (fl & ~19) | (a >> 7); end
      13: begin r = (a >> 1) | (c << 7);         nf = (fl & ~19) | (a & 1);  end
      14: begin
        q  = wa + wb;
        wr = q & 65535;
        nf = (fl & ~17) | (((wa ^ wb ^ q) >> 8) & 16) | ((q >> 16) & 1);
      end
      default: begin
        ah = wa >> 8; bh = wb >> 8;
        lo = (wa & 255) - (wb & 255);
        bl = (lo >> 8) & 1;
        hi = ah - bh - bl;
        wr = ((hi & 255) << 8) | (lo & 255);
        nf = (hi & 128) | ((((hi & 255) == 0) && ((lo & 255) == 0)) ? 64 : 0)
             | ((ah ^ bh ^ hi) & 16) | ((((ah ^ bh) & (ah ^ hi) & 128) != 0) ? 4 : 0)
             | 2 | ((hi >> 8) & 1);
      end
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic run_op(input int op, input int a, input int b, input int wa, input int wb,
                        input int er, input int ewr, input int ef, input string tag);
    op_sel = 4'(op); acc_in = 8'(a); opnd_in = 8'(b);
    wide_a = 16'(wa); wide_b = 16'(wb); op_en = 1'b1;
    #1;
    check((op >= 14) ? "R1" : tag, "result", {8'h00, result}, 16'(er));
    check((op >= 14) ? tag : "R1", "wide_res", wide_res, 16'(ewr));
    @(negedge clk);
    check(tag, "flags", {8'h00, flags_q}, 16'(ef));
    mflags = ef;
  endtask

  task automatic model_op(input int op, input int a, input int b, input int wa, input int wb);
    int er, ewr, ef;
    model(op, a, b, wa, wb, mflags, er, ewr, ef);
    run_op(op, a, b, wa, wb, er, ewr, ef, req_tag(op));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_en = 1'b0; op_sel = '0; acc_in = '0; opnd_in = '0;
    wide_a = '0; wide_b = '0;
    repeat (3) @(negedge clk);
    check("R2", "flags in reset", {8'h00, flags_q}, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2", "flags after release", {8'h00, flags_q}, 16'h0000);

    // hand-computed chain
    mflags = 0;
    for (int i = 0; i < 16; i++) begin
      run_op(int'(TBL[i][35:32]), int'(TBL[i][31:24]), int'(TBL[i][23:16]), 16'h1357, 16'h0000,
             int'(TBL[i][15:8]), 16'h1357, int'(TBL[i][7:0]), req_tag(int'(TBL[i][35:32])));
    end

    // wide corners (prior flags 0x93)
    run_op(14, 8'h3C, 0, 16'h0FFF, 16'h0001, 8'h3C, 16'h1000, 8'h92, "R8");
    run_op(14, 8'h3C, 0, 16'hFFFF, 16'h0001, 8'h3C, 16'h0000, 8'h93, "R8");
    run_op(15, 8'h3C, 0, 16'h1234, 16'h0034, 8'h3C, 16'h1200, 8'h02, "R9");
    run_op(15, 8'h3C, 0, 16'h0100, 16'h0001, 8'h3C, 16'h00FF, 8'h02, "R9");
    run_op(15, 8'h3C, 0, 16'h0000, 16'h0001, 8'h3C, 16'hFFFF, 8'h93, "R9");
    run_op(15, 8'h3C, 0, 16'h5555, 16'h5555, 8'h3C, 16'h0000, 8'h42, "R9");

    // R2: disabled operation leaves flags alone
    op_en = 1'b0; op_sel = 4'd0; acc_in = 8'hFF; opnd_in = 8'h01;
    @(negedge clk);
    check("R2", "flags hold", {8'h00, flags_q}, 16'h0042);
    check("R1", "result while idle", {8'h00, result}, 16'h0000);

    // R2: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1 check("R2", "async reset", {8'h00, flags_q}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mflags = 0;

    // model sweep, each op straight after a carry-forcing op
    for (int op = 0; op < 14; op++) begin
      for (int ai = 0; ai < 16; ai++) begin
        for (int bi = 0; bi < 16; bi++) begin
          for (int ci = 0; ci < 2; ci++) begin
            if (ci == 0) model_op(0, 0, 0, 0, 0);
            else         model_op(2, 0, 1, 0, 0);
            model_op(op, (ai * 17) & 255, (bi * 29 + 3) & 255, 16'hA5C3, 16'h0F0F);
          end
        end
      end
    end
    for (int op = 14; op < 16; op++) begin
      for (int i = 0; i < 32; i++) begin
        for (int j = 0; j < 32; j++) begin
          model_op(op, 8'h5A, 8'h11, (i * 2053) & 65535, (j * 4099 + 7) & 65535);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule